// File: doc/BRIEF.md
# Configurable Registered Command/Address Buffer

This block sits between a memory controller and the DRAM devices on a registered memory module. It captures command and address bits on the rising clock edge and re-drives them. One bank of flops serves two fan-out modes. In the wide mode, each of the 25 channels drives one output. In the narrow mode, each of the lower 14 channels drives two identical copies, called the A copy and the B copy. Two static configuration inputs choose the mode and, in the narrow mode, where the clock-enable and termination-control bits sit.

Two active-low chip-select inputs form a gate. When both are inactive on an edge, the ordinary data channels keep their previous value. The clock-enable, termination-control and registered chip-select channels are not gated and update on every edge. An asynchronous active-low reset clears every flop and forces every output low, whatever the gate is doing.

Channel numbering is 0-based in this project. Channel 6 always carries the registered chip select, taken from `dcsN`, and the input bus bit at that position is not used.

Top module: `cmd_regbuf`

## Requirements
- R1: With `cfgFanout` = 0 (wide mode), each `chanIn[k]` for k in 0..24 (except channel 6) is registered into `qA[k]`, and all of `qB` is driven 0.
- R2: With `cfgFanout` = 1 (narrow mode), channels 0..13 are registered, and `qB[k]` equals `qA[k]` for those channels. `qA[24:14]` and `qB[24:14]` are driven 0.
- R3: On a rising edge where `dcsN` = 0 or `csrN` = 0, every live gated channel loads its input. The new value appears at the output after that edge.
- R4: On a rising edge where `dcsN` = 1 and `csrN` = 1, every live gated channel keeps its previous output value, whatever is on `chanIn`.
- R5: The clock-enable and termination-control channels load on every edge, whatever the chip selects are. In wide mode, and in narrow mode with `cfgAlt` = 0, they are channel 0 (clock enable) and channel 3 (termination). In narrow mode with `cfgAlt` = 1, they are channel 13 (clock enable) and channel 10 (termination). In wide mode `cfgAlt` has no effect.
- R6: `qA[6]` (and `qB[6]` in narrow mode) takes the value of `dcsN` on every edge, whatever `csrN` is. `chanIn[6]` has no effect on any output.
- R7: `rstN` = 0 clears all outputs at once, without waiting for a clock edge. It takes priority over the chip-select gate.
- R8: After `rstN` rises, while `chanIn` = 0 and `dcsN` = 0, every output stays 0 on each following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Capture clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgFanout | input | 1 | 0: wide 1:1 mode, 1: narrow 1:2 mode (static) |
| cfgAlt | input | 1 | Narrow-mode control-bit placement select (static) |
| dcsN | input | 1 | Active-low chip select, also registered to channel 6 |
| csrN | input | 1 | Second active-low chip select, used only for gating |
| chanIn | input | 25 | Channel inputs; bit 6 unused |
| qA | output | 25 | Registered outputs, A copy |
| qB | output | 25 | Registered outputs, B copy (narrow mode only) |

## Verification
A wrong enable decode shows up one edge after the chip selects change. Either a gated channel moves while both selects are high, or an ungated control channel stops tracking. The per-cycle comparison against the model catches both on the same cycle. A wrong placement of the control bits appears only in the alternate narrow arrangement. So that arrangement is run with both selects held high long enough that channels 10 and 13 must differ from their gated neighbours. A stuck or unreset flop appears at the next compare after reset, either a mid-cycle assertion or a release with quiet inputs.

// File: rtl/regbuf_pkg.sv
package regbuf_pkg;

  // Strobes passed from the control decode to the register bank
  typedef struct packed {
    logic loadGated;  // at least one chip select active this edge
    logic fanoutTwo;  // narrow mode: drive the B copy
    logic altPlace;   // narrow mode, alternate control-bit placement
  } strobes_t;

endpackage

// File: rtl/regbuf_ctrl.sv
module regbuf_ctrl
  import regbuf_pkg::*;
#(
  parameter int CHANNELS = 25,
  parameter int HALF     = 14,
  parameter int CS_POS   = 6,
  parameter int CKE_A    = 0,
  parameter int ODT_A    = 3,
  parameter int CKE_B    = 13,
  parameter int ODT_B    = 10
) (
  input  logic                cfgFanout,
  input  logic                cfgAlt,
  input  logic                dcsN,
  input  logic                csrN,
  output strobes_t            strobes,
  output logic [CHANNELS-1:0] freeMask,
  output logic [CHANNELS-1:0] liveMask
);

  logic useAlt;

  always_comb begin
    useAlt            = cfgFanout & cfgAlt;
    strobes.loadGated = ~(dcsN & csrN);
    strobes.fanoutTwo = cfgFanout;
    strobes.altPlace  = useAlt;
  end

  for (genvar k = 0; k < CHANNELS; k++) begin : g_mask
    localparam bit IS_CS    = (k == CS_POS);
    localparam bit IS_CTL_A = (k == CKE_A) || (k == ODT_A);
    localparam bit IS_CTL_B = (k == CKE_B) || (k == ODT_B);
    localparam bit IN_HALF  = (k < HALF);

    always_comb begin
      liveMask[k] = ~cfgFanout | IN_HALF;
      freeMask[k] = IS_CS | (useAlt ? IS_CTL_B : IS_CTL_A);
    end
  end

endmodule

// File: rtl/regbuf_path.sv
module regbuf_path
  import regbuf_pkg::*;
#(
  parameter int CHANNELS = 25,
  parameter int CS_POS   = 6
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [CHANNELS-1:0] chanIn,
  input  logic                dcsN,
  input  strobes_t            strobes,
  input  logic [CHANNELS-1:0] freeMask,
  input  logic [CHANNELS-1:0] liveMask,
  output logic [CHANNELS-1:0] qA,
  output logic [CHANNELS-1:0] qB
);

  logic [CHANNELS-1:0] bankQ;

  for (genvar k = 0; k < CHANNELS; k++) begin : g_bit
    logic nextBit;
    logic loadEn;

    if (k == CS_POS) begin : g_cs
      always_comb nextBit = dcsN;
    end else begin : g_data
      always_comb nextBit = chanIn[k];
    end

    always_comb loadEn = freeMask[k] | strobes.loadGated;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)             bankQ[k] <= 1'b0;
      else if (!liveMask[k]) bankQ[k] <= 1'b0;
      else if (loadEn)       bankQ[k] <= nextBit;
    end
  end

  always_comb begin
    qA = bankQ;
    qB = strobes.fanoutTwo ? bankQ : '0;
  end

endmodule

// File: rtl/cmd_regbuf.sv
module cmd_regbuf
  import regbuf_pkg::*;
#(
  parameter int CHANNELS = 25,
  parameter int HALF     = 14,
  parameter int CS_POS   = 6,
  parameter int CKE_A    = 0,
  parameter int ODT_A    = 3,
  parameter int CKE_B    = 13,
  parameter int ODT_B    = 10
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cfgFanout,
  input  logic                cfgAlt,
  input  logic                dcsN,
  input  logic                csrN,
  input  logic [CHANNELS-1:0] chanIn,
  output logic [CHANNELS-1:0] qA,
  output logic [CHANNELS-1:0] qB
);

  strobes_t            strobes;
  logic [CHANNELS-1:0] freeMask;
  logic [CHANNELS-1:0] liveMask;

  regbuf_ctrl #(
    .CHANNELS(CHANNELS), .HALF(HALF), .CS_POS(CS_POS),
    .CKE_A(CKE_A), .ODT_A(ODT_A), .CKE_B(CKE_B), .ODT_B(ODT_B)
  ) ctrl_i (
    .cfgFanout(cfgFanout),
    .cfgAlt   (cfgAlt),
    .dcsN     (dcsN),
    .csrN     (csrN),
    .strobes  (strobes),
    .freeMask (freeMask),
    .liveMask (liveMask)
  );

  regbuf_path #(
    .CHANNELS(CHANNELS), .CS_POS(CS_POS)
  ) path_i (
    .clk     (clk),
    .rstN    (rstN),
    .chanIn  (chanIn),
    .dcsN    (dcsN),
    .strobes (strobes),
    .freeMask(freeMask),
    .liveMask(liveMask),
    .qA      (qA),
    .qB      (qB)
  );

endmodule

// File: rtl/regbuf_chk.sv
module regbuf_chk #(
  parameter int CHANNELS = 25,
  parameter int HALF     = 14,
  parameter int CS_POS   = 6,
  parameter int CKE_A    = 0,
  parameter int ODT_A    = 3,
  parameter int CKE_B    = 13,
  parameter int ODT_B    = 10
) (
  input logic                clk,
  input logic                rstN,
  input logic                cfgFanout,
  input logic                cfgAlt,
  input logic                dcsN,
  input logic                csrN,
  input logic [CHANNELS-1:0] chanIn,
  input logic [CHANNELS-1:0] qA,
  input logic [CHANNELS-1:0] qB
);

  // Channels that the chip-select gate can freeze in the current configuration
  function automatic logic [CHANNELS-1:0] heldSet(input logic fan, input logic alt);
    logic [CHANNELS-1:0] m;
    for (int k = 0; k < CHANNELS; k++) begin
      m[k] = 1'b1;
      if (fan && k >= HALF) m[k] = 1'b0;
      if (k == CS_POS) m[k] = 1'b0;
      if (fan && alt) begin
        if (k == CKE_B || k == ODT_B) m[k] = 1'b0;
      end else begin
        if (k == CKE_A || k == ODT_A) m[k] = 1'b0;
      end
    end
    return m;
  endfunction

  logic [CHANNELS-1:0] heldM;
  logic [CHANNELS-1:0] upperM;
  always_comb begin
    heldM = heldSet(cfgFanout, cfgAlt);
    for (int k = 0; k < CHANNELS; k++) upperM[k] = (k >= HALF);
  end

  // R7: reset forces every output low
  p_reset_clear_r7: assert property (@(posedge clk)
    !rstN |-> (qA == '0 && qB == '0));

  // R4: both selects inactive freezes gated channels
  p_hold_gated_r4: assert property (@(posedge clk) disable iff (!rstN)
    (dcsN && csrN) |=> ((qA & heldM) == ($past(qA) & heldM)));

  // R3: a selected edge loads gated channels
  p_load_gated_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!dcsN || !csrN) |=> ((qA & heldM) == ($past(chanIn) & heldM)));

  // R6: registered chip select follows dcsN
  p_cs_follow_r6: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (qA[CS_POS] == $past(dcsN)));

  // R2: narrow mode copies and upper channels
  p_copy_b_r2: assert property (@(posedge clk) disable iff (!rstN)
    cfgFanout |-> (qB == qA && (qA & upperM) == '0));

  // R1: wide mode keeps the B copy low
  p_b_low_r1: assert property (@(posedge clk) disable iff (!rstN)
    !cfgFanout |-> (qB == '0));

endmodule

bind cmd_regbuf regbuf_chk #(
  .CHANNELS(CHANNELS), .HALF(HALF), .CS_POS(CS_POS),
  .CKE_A(CKE_A), .ODT_A(ODT_A), .CKE_B(CKE_B), .ODT_B(ODT_B)
) chk_i (.*);

// File: tb/cmd_regbuf_tb_top.sv
`timescale 1ns/1ps
module cmd_regbuf_tb_top;

  localparam int N = 25;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         cfgFanout = 1'b0;
  logic         cfgAlt = 1'b0;
  logic         dcsN = 1'b0;
  logic         csrN = 1'b0;
  logic [N-1:0] chanIn = '0;
  logic [N-1:0] qA;
  logic [N-1:0] qB;

  int    tests = 0;
  int    fails = 0;
  bit    checkOn = 1'b0;
  string tag = "R1";

  logic [N-1:0] modelQ;

  always #2.5 clk = ~clk;

  cmd_regbuf dut_i (
    .clk(clk), .rstN(rstN), .cfgFanout(cfgFanout), .cfgAlt(cfgAlt),
    .dcsN(dcsN), .csrN(csrN), .chanIn(chanIn), .qA(qA), .qB(qB)
  );

  // Next-state from the requirements R1..R6
  function automatic logic [N-1:0] stepModel(
      input logic [N-1:0] prev, input logic [N-1:0] din,
      input logic dcs, input logic csr, input logic c1, input logic c0);
    logic [N-1:0] r;
    int cke, odt;
    cke = (c1 && c0) ? 13 : 0;
    odt = (c1 && c0) ? 10 : 3;
    for (int k = 0; k < N; k++) begin
      if (c1 && k >= 14)                        r[k] = 1'b0;
      else if (k == 6)                          r[k] = dcs;
      else if (k == cke || k == odt || !(dcs && csr)) r[k] = din[k];
      else                                      r[k] = prev[k];
    end
    return r;
  endfunction

  function automatic logic [N-1:0] expB(input logic [N-1:0] a, input logic c1);
    return c1 ? a : '0;
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) modelQ <= '0;
    else       modelQ <= stepModel(modelQ, chanIn, dcsN, csrN, cfgFanout, cfgAlt);
  end

  task automatic checkOut(input string lbl);
    tests++;
    if (qA !== modelQ || qB !== expB(modelQ, cfgFanout)) begin
      fails++;
      $display("FAIL %s: qA=%h qB=%h expected qA=%h qB=%h",
               lbl, qA, qB, modelQ, expB(modelQ, cfgFanout));
    end
  endtask

  always @(negedge clk) if (checkOn) checkOut(tag);

  task automatic cycleAfterEdge();
    @(posedge clk);
    #1;
  endtask

  task automatic doReset(input logic c1, input logic c0);
    cycleAfterEdge();
    rstN = 1'b0;
    chanIn = '0; dcsN = 1'b0; csrN = 1'b0;
    cfgFanout = c1; cfgAlt = c0;
    repeat (3) cycleAfterEdge();
    rstN = 1'b1;
  endtask

  task automatic randomCycles(input int n);
    for (int i = 0; i < n; i++) begin
      cycleAfterEdge();
      chanIn = N'($urandom);
      dcsN = 1'($urandom);
      csrN = 1'($urandom);
    end
  endtask

  initial begin
    void'($urandom(32'd4242));
    // reset state, R7
    repeat (3) cycleAfterEdge();
    #0.5;
    tests++;
    if (qA !== '0 || qB !== '0) begin
      fails++;
      $display("FAIL R7: qA=%h qB=%h expected 0", qA, qB);
    end
    checkOn = 1'b1;

    // R8: quiet release keeps outputs low
    tag = "R8";
    rstN = 1'b1;
    repeat (4) cycleAfterEdge();

    for (int cfg = 0; cfg < 4; cfg++) begin
      logic c1, c0;
      c1 = cfg[1]; c0 = cfg[0];
      tag = c1 ? "R2/R3/R4/R5/R6" : "R1/R3/R4/R5/R6";
      doReset(c1, c0);
      randomCycles(250);
      // R4/R5 directed: both selects high while data toggles
      for (int i = 0; i < 6; i++) begin
        cycleAfterEdge();
        dcsN = 1'b1; csrN = 1'b1;
        chanIn = (i % 2 == 0) ? {N{1'b1}} : '0;
      end
      // R3: each single select low loads
      cycleAfterEdge(); dcsN = 1'b0; csrN = 1'b1; chanIn = N'(25'h0AAAAA);
      cycleAfterEdge(); dcsN = 1'b1; csrN = 1'b0; chanIn = N'(25'h155555);
      cycleAfterEdge(); dcsN = 1'b1; csrN = 1'b1; chanIn = '0;
      randomCycles(40);
      // R7: reset asserted mid-cycle clears at once, gate held
      tag = "R7";
      dcsN = 1'b1; csrN = 1'b1;
      rstN = 1'b0;
      #0.5;
      tests++;
      if (qA !== '0 || qB !== '0) begin
        fails++;
        $display("FAIL R7: qA=%h qB=%h expected 0 during reset", qA, qB);
      end
      cycleAfterEdge();
      rstN = 1'b1;
      randomCycles(20);
    end

    checkOn = 1'b0;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #1_000_000;
    fails++;
    tests++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule